// File: doc/BRIEF.md
# Page Program Data Buffer

This block gathers the data bytes of a page-program command into a page-wide staging buffer and, once the command frame closes cleanly, commits them to the storage array one column at a time. A command begins with a start strobe, then a 20-bit target address: the upper bits pick the page and the low byte picks the first column. Each later data byte goes into the next column. The column counter wraps inside the page, so a stream longer than one page keeps only the most recent page-worth of bytes.

When chip select rises, the block decides whether to program. It needs a clean byte boundary, a grant from the protection logic, and at least one loaded byte. If all three hold, it pulses a start strobe and goes busy. It then scans the columns in ascending order. For each column that was loaded, it reads the current array byte and writes back the bitwise AND of that byte with the new data, so cells can only go from 1 to 0. Columns that were never loaded are left alone. Busy drops when the scan ends and serves as the ready/busy indication.

The controller is a four-state machine:
- `ST_IDLE` waits for a command.
- `ST_LOAD` accepts the address and data.
- `ST_FETCH` looks at a column and, if it was loaded, issues an array read.
- `ST_MERGE` writes the merged byte.

Its transitions are:
- IDLE→LOAD on the start strobe.
- LOAD→FETCH when the commit conditions are met at chip-select rise.
- LOAD→IDLE on a cancelled commit.
- FETCH→MERGE for a loaded column.
- FETCH→FETCH for a skipped column.
- MERGE→FETCH while columns remain.
- FETCH/MERGE→IDLE after the last column.

Top module: `pgbuf_top`

## Requirements
- R1: After reset, `prog_start`, `busy`, `arr_rd_en` and `arr_wr_en` are all low.
- R2: A `cmd_start` pulse while idle empties the buffer. Only bytes loaded after that pulse are ever written to the array.
- R3: The page is `addr_in[19:8]` and the first column is `addr_in[7:0]`. Data byte k of a command goes to column (start + k) mod 256 of that page. Array addresses are {page, column}.
- R4: After column 255 the next byte goes to column 0 of the same page. When more than 256 bytes arrive, each column holds the last byte sent to it.
- R5: A `cs_rise` pulse with `byte_aligned`=1 and `prog_allow`=1, after at least one byte was loaded, produces a one-cycle `prog_start` in the following cycle. `busy` is high from that same cycle until the scan ends.
- R6: A `cs_rise` with `byte_aligned`=0 cancels the command: no `prog_start` and no array write.
- R7: A `cs_rise` with `prog_allow`=0 cancels the command: no `prog_start` and no array write.
- R8: A `cs_rise` with no data byte loaded produces no `prog_start` and no array write.
- R9: Only loaded columns are written, each exactly once. Each write is preceded in the previous cycle by an `arr_rd_en` to the same address. The array returns `arr_rdata` in the cycle after `arr_rd_en`.
- R10: Each written byte equals the old array byte ANDed with the buffered byte.
- R11: While `busy` is high, `cmd_start`, `addr_valid`, `byte_valid` and `cs_rise` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Pulse marking the start of a page-program command |
| addr_valid | input | 1 | Strobe for `addr_in` |
| addr_in | input | 20 | Target address: page in [19:8], first column in [7:0] |
| byte_valid | input | 1 | Strobe for `byte_in` |
| byte_in | input | 8 | Data byte |
| cs_rise | input | 1 | Pulse marking the chip-select rise that ends the frame |
| byte_aligned | input | 1 | Frame ended on a whole byte (valid with `cs_rise`) |
| prog_allow | input | 1 | Protection grant (valid with `cs_rise`) |
| prog_start | output | 1 | One-cycle pulse at the start of programming |
| busy | output | 1 | Programming in progress |
| arr_rd_en | output | 1 | Array read request |
| arr_wr_en | output | 1 | Array write strobe |
| arr_addr | output | 20 | Array address {page, column} |
| arr_wdata | output | 8 | Merged byte to write |
| arr_rdata | input | 8 | Array read data, one cycle after `arr_rd_en` |

## Verification
The hardest case to reach is a stream longer than one page that wraps the column counter. Columns written twice must keep only their second byte, while the merge still ANDs against the old array contents. The bench sends 258 bytes with values that differ between the first and second pass over columns 0 and 1. It then checks those columns and an untouched neighbour, and counts array writes to confirm 256. A second hard case is traffic arriving during the scan. The bench injects a complete command while `busy` is high and confirms that nothing at the injected address changes.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_FETCH = 2'd2,
        ST_MERGE = 2'd3
    } pg_state_t;
endpackage

// File: rtl/pgbuf_loader.sv
module pgbuf_loader #(
    parameter int ADDR_W = 20,
    parameter int COL_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    en,
    input  logic                    addr_valid,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic                    byte_valid,
    output logic [ADDR_W-COL_W-1:0] page_q,
    output logic [COL_W-1:0]        col_q,
    output logic                    store_we
);
    localparam int PAGE_W = ADDR_W - COL_W;
    localparam logic [COL_W-1:0] COL_LAST = '1;

    logic have_addr;

    assign store_we = en && have_addr && byte_valid && !addr_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_addr <= 1'b0;
            page_q    <= '0;
            col_q     <= '0;
        end else if (clear) begin
            have_addr <= 1'b0;
            col_q     <= '0;
        end else if (en && addr_valid) begin
            have_addr <= 1'b1;
            page_q    <= addr_in[ADDR_W-1:COL_W];
            col_q     <= addr_in[COL_W-1:0];
        end else if (store_we) begin
            col_q <= col_q + 1'b1;
        end
    end

    // R4: column wraps inside the page
    p_col_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_we && !clear && col_q == COL_LAST) |=> (col_q == '0));

    // R3: page stays fixed while bytes stream in
    p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (store_we && !clear) |=> (page_q == $past(page_q)));

    logic [PAGE_W-1:0] unused_page_w;
    assign unused_page_w = page_q;
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int COL_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              we,
    input  logic [COL_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [COL_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              any_valid
);
    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clear) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[waddr] <= 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[g] <= '1;
                else if (clear)
                    mem_q[g] <= '1;
                else if (we && waddr == COL_W'(g))
                    mem_q[g] <= wdata;
            end
        end
    endgenerate

    assign rdata     = mem_q[raddr];
    assign rvalid    = valid_q[raddr];
    assign any_valid = |valid_q;

    // R2: a clear leaves no column marked as loaded
    p_clear_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !any_valid);
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cs_rise,
    input  logic             byte_aligned,
    input  logic             prog_allow,
    input  logic             any_valid,
    input  logic             col_valid,
    output logic [COL_W-1:0] scan_q,
    output logic             clear,
    output logic             load_en,
    output logic             rd_en,
    output logic             wr_en,
    output logic             busy,
    output logic             prog_start
);
    localparam logic [COL_W-1:0] COL_LAST = '1;

    pg_state_t state_q, state_d;
    logic      commit;

    assign commit = cs_rise && byte_aligned && prog_allow && any_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_start) state_d = ST_LOAD;
            ST_LOAD:  if (cs_rise) state_d = commit ? ST_FETCH : ST_IDLE;
            ST_FETCH: begin
                if (col_valid)
                    state_d = ST_MERGE;
                else if (scan_q == COL_LAST)
                    state_d = ST_IDLE;
            end
            ST_MERGE: state_d = (scan_q == COL_LAST) ? ST_IDLE : ST_FETCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            scan_q     <= '0;
            prog_start <= 1'b0;
        end else begin
            state_q    <= state_d;
            prog_start <= (state_q == ST_LOAD) && commit;
            if (state_q == ST_LOAD)
                scan_q <= '0;
            else if ((state_q == ST_FETCH && !col_valid) || state_q == ST_MERGE)
                scan_q <= scan_q + 1'b1;
        end
    end

    always_comb begin
        clear   = 1'b0;
        load_en = 1'b0;
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE:  clear = cmd_start;
            ST_LOAD:  load_en = !cs_rise;
            ST_FETCH: begin busy = 1'b1; rd_en = col_valid; end
            ST_MERGE: begin busy = 1'b1; wr_en = 1'b1; end
            default:  ;
        endcase
    end

    // R5: start strobe only after a clean commit request
    p_start_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $past(cs_rise && byte_aligned && prog_allow));

    // R6: a ragged frame end never starts programming
    p_ragged_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !byte_aligned) |=> !prog_start);

    // R9: each write follows a read of the same column
    p_read_before_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(rd_en) && scan_q == $past(scan_q)));

    // R9: never read and write in one cycle
    p_port_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_en, wr_en}));

    // R11: no clearing while the scan runs
    p_busy_no_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !clear);
endmodule

// File: rtl/pgbuf_top.sv
module pgbuf_top #(
    parameter int ADDR_W = 20,
    parameter int COL_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              cs_rise,
    input  logic              byte_aligned,
    input  logic              prog_allow,
    output logic              prog_start,
    output logic              busy,
    output logic              arr_rd_en,
    output logic              arr_wr_en,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [DATA_W-1:0] arr_rdata
);
    localparam int PAGE_W = ADDR_W - COL_W;

    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q, scan_q;
    logic              store_we, clear, load_en;
    logic [DATA_W-1:0] buf_rdata;
    logic              col_valid, any_valid;

    pgbuf_loader #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_loader (
        .clk(clk), .rst_n(rst_n), .clear(clear), .en(load_en),
        .addr_valid(addr_valid), .addr_in(addr_in), .byte_valid(byte_valid),
        .page_q(page_q), .col_q(col_q), .store_we(store_we)
    );

    pgbuf_store #(.COL_W(COL_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear), .we(store_we),
        .waddr(col_q), .wdata(byte_in), .raddr(scan_q),
        .rdata(buf_rdata), .rvalid(col_valid), .any_valid(any_valid)
    );

    pgbuf_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cs_rise(cs_rise),
        .byte_aligned(byte_aligned), .prog_allow(prog_allow),
        .any_valid(any_valid), .col_valid(col_valid), .scan_q(scan_q),
        .clear(clear), .load_en(load_en), .rd_en(arr_rd_en), .wr_en(arr_wr_en),
        .busy(busy), .prog_start(prog_start)
    );

    assign arr_addr  = {page_q, scan_q};
    assign arr_wdata = arr_rdata & buf_rdata;

    // R10: a write never sets a bit that the array read back as 0
    p_only_clear_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> ((arr_wdata & ~arr_rdata) == '0));

    // R8: nothing starts without a loaded byte
    p_no_empty_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !any_valid) |=> !prog_start);
endmodule

// File: tb/pgbuf_top_tb_top.sv
module pgbuf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 0, addr_valid = 0, byte_valid = 0;
    logic [19:0] addr_in = '0;
    logic [7:0]  byte_in = '0;
    logic        cs_rise = 0, byte_aligned = 0, prog_allow = 0;
    logic        prog_start, busy, arr_rd_en, arr_wr_en;
    logic [19:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic [7:0]  arr_rdata = '0;

    int checks = 0, errors = 0;
    int n_start = 0, n_wr = 0, cyc = 0;
    logic [7:0] amem [int];

    always #2 clk = ~clk;

    pgbuf_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .addr_valid(addr_valid),
        .addr_in(addr_in), .byte_valid(byte_valid), .byte_in(byte_in),
        .cs_rise(cs_rise), .byte_aligned(byte_aligned), .prog_allow(prog_allow),
        .prog_start(prog_start), .busy(busy), .arr_rd_en(arr_rd_en),
        .arr_wr_en(arr_wr_en), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata)
    );

    function automatic logic [7:0] mrd(input int a);
        return amem.exists(a) ? amem[a] : 8'hFF;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (arr_rd_en) arr_rdata <= mrd(int'(arr_addr));
        if (arr_wr_en) begin amem[int'(arr_addr)] = arr_wdata; n_wr <= n_wr + 1; end
        if (prog_start) n_start <= n_start + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic begin_cmd(input logic [19:0] a);
        @(negedge clk) cmd_start = 1;
        @(negedge clk) cmd_start = 0; addr_valid = 1; addr_in = a;
        @(negedge clk) addr_valid = 0;
    endtask

    task automatic put_byte(input logic [7:0] d);
        byte_valid = 1; byte_in = d;
        @(negedge clk) byte_valid = 0;
    endtask

    task automatic end_cmd(input logic al, input logic ok);
        cs_rise = 1; byte_aligned = al; prog_allow = ok;
        @(negedge clk) cs_rise = 0; byte_aligned = 0; prog_allow = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 prog_start", prog_start, 0);
        chk("R1 busy", busy, 0);
        chk("R1 rd/wr", {arr_rd_en, arr_wr_en}, 0);
    endtask

    task automatic t_single();
        int s0, w0;
        amem[32'h12305] = 8'hF0;
        s0 = n_start; w0 = n_wr;
        begin_cmd(20'h12305);
        put_byte(8'h3C);
        end_cmd(1, 1);
        chk("R5 prog_start pulse", prog_start, 1);
        chk("R5 busy", busy, 1);
        @(negedge clk);
        chk("R5 single pulse", prog_start, 0);
        wait_idle();
        chk("R10 merged byte", mrd(32'h12305), 8'h30);
        chk("R9 neighbour untouched", mrd(32'h12306), 8'hFF);
        chk("R9 write count", n_wr - w0, 1);
        chk("R5 start count", n_start - s0, 1);
    endtask

    task automatic t_wrap();
        int w0;
        w0 = n_wr;
        begin_cmd(20'h0ABFE);
        put_byte(8'h11); put_byte(8'h22); put_byte(8'h33); put_byte(8'h44);
        end_cmd(1, 1);
        wait_idle();
        chk("R3 col FE", mrd(32'h0ABFE), 8'h11);
        chk("R3 col FF", mrd(32'h0ABFF), 8'h22);
        chk("R4 wrap col 00", mrd(32'h0AB00), 8'h33);
        chk("R4 wrap col 01", mrd(32'h0AB01), 8'h44);
        chk("R4 no page spill", mrd(32'h0AC00), 8'hFF);
        chk("R9 write count", n_wr - w0, 4);
    endtask

    task automatic t_overflow();
        int w0;
        w0 = n_wr;
        begin_cmd(20'h20000);
        for (int i = 0; i < 258; i++)
            put_byte(8'(i) ^ ((i >= 256) ? 8'hA5 : 8'h00));
        end_cmd(1, 1);
        wait_idle();
        chk("R4 col0 last byte", mrd(32'h20000), 8'hA5);
        chk("R4 col1 last byte", mrd(32'h20001), 8'hA4);
        chk("R4 col2", mrd(32'h20002), 8'h02);
        chk("R4 colFF", mrd(32'h200FF), 8'hFF);
        chk("R9 write count 256", n_wr - w0, 256);
    endtask

    task automatic t_fresh();
        int w0;
        w0 = n_wr;
        begin_cmd(20'h20010);
        put_byte(8'h0F);
        end_cmd(1, 1);
        wait_idle();
        chk("R2 only new byte written", n_wr - w0, 1);
        chk("R10 AND with old", mrd(32'h20010), 8'h00);
    endtask

    task automatic t_cancel(input string req, input logic al, input logic ok, input logic with_byte);
        int s0, w0;
        s0 = n_start; w0 = n_wr;
        begin_cmd(20'h30000);
        if (with_byte) put_byte(8'h00);
        end_cmd(al, ok);
        repeat (4) @(negedge clk);
        chk(req, n_start - s0, 0);
        chk(req, n_wr - w0, 0);
        chk(req, mrd(32'h30000), 8'hFF);
    endtask

    task automatic t_busy_ignore();
        int s0;
        s0 = n_start;
        begin_cmd(20'h40000);
        put_byte(8'h00);
        end_cmd(1, 1);
        begin_cmd(20'h50000);
        put_byte(8'h00);
        end_cmd(1, 1);
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R11 one start only", n_start - s0, 1);
        chk("R11 injected addr untouched", mrd(32'h50000), 8'hFF);
        chk("R11 real byte programmed", mrd(32'h40000), 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_single();
        t_wrap();
        t_overflow();
        t_fresh();
        t_cancel("R6 ragged end", 0, 1, 1);
        t_cancel("R7 not allowed", 1, 0, 1);
        t_cancel("R8 no bytes", 1, 1, 0);
        t_busy_ignore();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule